// File: doc/BRIEF.md
# Stereo Audio Sample Queue with Pulse-Density Outputs

This block plays stereo audio that a processor supplies ahead of time. The processor writes 32-bit stereo words into an on-chip first-in first-out buffer. A fractional rate divider produces a sample strobe that averages exactly `RATE_HZ` from a `CLK_HZ` clock. On each strobe the block takes one stereo word from the buffer and makes it the current output sample. Each channel has a first-order error-accumulating modulator that turns the current sample into a one-bit pulse-density stream on its own pin. An external RC low-pass network on each pin recovers the analog signal. The processor watches the fill level, full and empty outputs to keep the buffer topped up.

If the buffer runs dry at a strobe, the previous sample keeps playing and a sticky underflow flag is raised. A compatibility mode serves software written for simple 8-bit parallel-port DACs. In that mode a directly written unsigned byte drives both modulators and the buffer is bypassed. The buffer is frozen while that mode is active.

Top module: `audio_pdm_queue`

## Requirements
- R1: After reset the buffer is empty: `q_empty`=1, `q_full`=0, `q_level`=0, and `underflow`=0. The legacy byte resets to 0x80 and the current sample resets to signed zero, so both pins carry a 50% pulse density.
- R2: A `wr_en` pulse that finds the buffer not full stores `wr_data`, and `q_level` rises by one at the next edge. `q_full` is 1 exactly when `q_level` equals `DEPTH`. A write that finds the buffer full is dropped, and `q_level` stays at `DEPTH`.
- R3: Sample strobes come from a fractional accumulator. With `CLK_HZ`=3000 and `RATE_HZ`=10 they fall exactly every 300 clocks. Each strobe in normal mode that finds the buffer non-empty removes one word, and `q_level` falls by one.
- R4: Words are played in the order they were written. Bits 31:16 are the signed left sample, which drives `pdm_left`. Bits 15:0 are the signed right sample, which drives `pdm_right`.
- R5: Each pin's count of ones over any 256 consecutive clocks is within 1 of (u >> 8). Here u is the channel's 16-bit modulator input: the signed sample with its sign bit inverted (offset binary). The pin starts showing a new sample at the edge after the sample changes.
- R6: A strobe in normal mode that finds the buffer empty keeps the current sample and sets `underflow`. The flag then stays set until reset.
- R7: While `legacy_en`=1, both modulators take u = {legacy byte, 8'h00}. A `legacy_wr` pulse loads `legacy_data` into the legacy byte.
- R8: While `legacy_en`=1, strobes remove no words and never set `underflow`. Writes to the buffer are still accepted.
- R9: A write and a strobe removal at the same edge leave `q_level` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Push `wr_data` into the buffer |
| wr_data | input | 32 | Stereo word: left in 31:16, right in 15:0, both signed |
| legacy_en | input | 1 | Select the direct 8-bit path and freeze the buffer |
| legacy_wr | input | 1 | Load `legacy_data` into the legacy byte |
| legacy_data | input | 8 | Unsigned direct sample level |
| pdm_left | output | 1 | Left channel pulse-density stream |
| pdm_right | output | 1 | Right channel pulse-density stream |
| q_full | output | 1 | Buffer holds `DEPTH` words |
| q_empty | output | 1 | Buffer holds no words |
| q_level | output | $clog2(DEPTH)+1 | Number of stored words |
| underflow | output | 1 | Sticky: a strobe found the buffer empty |

## Verification
The results have different latencies, and the bench samples each one at its own cycle:
- **Writes:** `q_level`, `q_full` and `q_empty` change at the edge that takes the write.
- **Strobe removals:** `q_level` falls and the current sample changes at the same edge.
- **Pins after a removal:** the pins show the new sample one edge after the removal. The bench syncs on the observed fall of `q_level`, skips one edge, and then counts ones over 256 clocks, well before the next strobe.
- **Legacy bytes:** a byte reaches the pins two edges after its write.
- **Simultaneous write and removal:** the bench places the write exactly 300 clocks after an observed removal.

All values are sampled on the falling clock edge.

// File: rtl/apq_pkg.sv
package apq_pkg;
    localparam int SAMPLE_W = 16;
    localparam int WORD_W   = 2 * SAMPLE_W;
    localparam int BYTE_W   = 8;
    localparam int NUM_CH   = 2;

    typedef logic [SAMPLE_W-1:0] sample_t;

    typedef struct packed {
        sample_t left;
        sample_t right;
    } stereo_t;

    // signed two's complement to offset binary
    function automatic sample_t to_offset(input sample_t s);
        return {~s[SAMPLE_W-1], s[SAMPLE_W-2:0]};
    endfunction
endpackage

// File: rtl/apq_rate_tick.sv
module apq_rate_tick #(
    parameter int unsigned CLK_HZ  = 80_000_000,
    parameter int unsigned RATE_HZ = 44_100
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int ACC_W = $clog2(CLK_HZ + RATE_HZ) + 1;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             tick;
    } tick_st_t;

    tick_st_t         s_d, s_q;
    logic [ACC_W-1:0] sum;

    always_comb begin
        s_d = s_q;
        sum = s_q.acc + ACC_W'(RATE_HZ);
        if (sum >= ACC_W'(CLK_HZ)) begin
            s_d.acc  = sum - ACC_W'(CLK_HZ);
            s_d.tick = 1'b1;
        end else begin
            s_d.acc  = sum;
            s_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick = s_q.tick;
endmodule

// File: rtl/apq_fifo.sv
module apq_fifo #(
    parameter int DEPTH = 4096,
    parameter int W     = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push,
    input  logic [W-1:0]             push_data,
    input  logic                     pop,
    output logic [W-1:0]             head,
    output logic                     full,
    output logic                     empty,
    output logic [$clog2(DEPTH):0]   level
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t     s_d, s_q;
    logic [W-1:0] mem [DEPTH];
    logic         do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d     = s_q;
        do_pop  = pop && (s_q.cnt != '0);
        do_push = push && (s_q.cnt != CW'(DEPTH));
        if (do_push) s_d.wr = bump(s_q.wr);
        if (do_pop)  s_d.rd = bump(s_q.rd);
        case ({do_push, do_pop})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[s_q.wr] <= push_data;
    end

    assign head  = mem[s_q.rd];
    assign full  = (s_q.cnt == CW'(DEPTH));
    assign empty = (s_q.cnt == '0);
    assign level = s_q.cnt;
endmodule

// File: rtl/apq_pdm.sv
module apq_pdm #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    output logic         bit_out
);
    typedef struct packed {
        logic [W-1:0] acc;
        logic         bit_o;
    } pdm_st_t;

    pdm_st_t    s_d, s_q;
    logic [W:0] sum;

    always_comb begin
        s_d       = s_q;
        sum       = {1'b0, s_q.acc} + {1'b0, level};
        s_d.acc   = sum[W-1:0];
        s_d.bit_o = sum[W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bit_out = s_q.bit_o;
endmodule

// File: rtl/audio_pdm_queue.sv
module audio_pdm_queue
    import apq_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 80_000_000,
    parameter int unsigned RATE_HZ = 44_100,
    parameter int          DEPTH   = 4096
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [WORD_W-1:0]      wr_data,
    input  logic                   legacy_en,
    input  logic                   legacy_wr,
    input  logic [BYTE_W-1:0]      legacy_data,
    output logic                   pdm_left,
    output logic                   pdm_right,
    output logic                   q_full,
    output logic                   q_empty,
    output logic [$clog2(DEPTH):0] q_level,
    output logic                   underflow
);
    localparam int PAD_W = SAMPLE_W - BYTE_W;

    typedef struct packed {
        stereo_t           cur;
        logic [BYTE_W-1:0] lbyte;
        logic              underflow;
    } top_st_t;

    top_st_t           s_d, s_q;
    logic              tick, pop;
    logic [WORD_W-1:0] head;
    sample_t           chan_lvl [NUM_CH];
    logic [NUM_CH-1:0] pdm_bits;

    apq_rate_tick #(.CLK_HZ(CLK_HZ), .RATE_HZ(RATE_HZ)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    apq_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (wr_en),
        .push_data(wr_data),
        .pop      (pop),
        .head     (head),
        .full     (q_full),
        .empty    (q_empty),
        .level    (q_level)
    );

    always_comb begin
        s_d = s_q;
        pop = tick && !legacy_en;
        if (legacy_wr) s_d.lbyte = legacy_data;
        if (pop) begin
            if (!q_empty) s_d.cur       = stereo_t'(head);
            else          s_d.underflow = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cur       <= '0;
            s_q.lbyte     <= {1'b1, {(BYTE_W-1){1'b0}}};
            s_q.underflow <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        if (legacy_en) begin
            chan_lvl[0] = {s_q.lbyte, {PAD_W{1'b0}}};
            chan_lvl[1] = {s_q.lbyte, {PAD_W{1'b0}}};
        end else begin
            chan_lvl[0] = to_offset(s_q.cur.left);
            chan_lvl[1] = to_offset(s_q.cur.right);
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        apq_pdm #(.W(SAMPLE_W)) u_mod (
            .clk    (clk),
            .rst_n  (rst_n),
            .level  (chan_lvl[c]),
            .bit_out(pdm_bits[c])
        );
    end

    assign pdm_left  = pdm_bits[0];
    assign pdm_right = pdm_bits[1];
    assign underflow = s_q.underflow;
endmodule

// File: rtl/apq_checker.sv
module apq_checker #(
    parameter int DEPTH = 4096
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   legacy_en,
    input logic                   q_full,
    input logic                   q_empty,
    input logic [$clog2(DEPTH):0] q_level,
    input logic                   underflow
);
    // R2
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(q_level) <= DEPTH);

    // R2
    full_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_full |-> !q_empty);

    // R8
    legacy_no_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        legacy_en |=> int'(q_level) >= int'($past(q_level)));

    // R6
    underflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow);

    // R6
    underflow_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underflow) |-> $past(q_empty));

    // R9
    level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(q_level) <= int'($past(q_level)) + 1) &&
        (int'(q_level) + 1 >= int'($past(q_level))));
endmodule

bind audio_pdm_queue apq_checker #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .legacy_en(legacy_en),
    .q_full   (q_full),
    .q_empty  (q_empty),
    .q_level  (q_level),
    .underflow(underflow)
);

// File: tb/audio_pdm_queue_test.sv
module audio_pdm_queue_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int LW         = $clog2(DEPTH) + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [31:0]   wr_data = '0;
    logic          legacy_en = 1'b0;
    logic          legacy_wr = 1'b0;
    logic [7:0]    legacy_data = '0;
    logic          pdm_left, pdm_right, q_full, q_empty, underflow;
    logic [LW-1:0] q_level;

    int checks = 0;
    int fails  = 0;
    logic [31:0] words [DEPTH];

    audio_pdm_queue #(.CLK_HZ(3000), .RATE_HZ(10), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .legacy_en(legacy_en), .legacy_wr(legacy_wr), .legacy_data(legacy_data),
        .pdm_left(pdm_left), .pdm_right(pdm_right), .q_full(q_full),
        .q_empty(q_empty), .q_level(q_level), .underflow(underflow)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int exp_ones(input logic [15:0] s);
        return int'({~s[15], s[14:0]} >> 8);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_density(input string tag, input int act, input int exp);
        check(act >= exp - 1 && act <= exp + 1, tag, act, exp);
    endtask

    task automatic measure(output int l, output int r);
        l = 0; r = 0;
        @(negedge clk);
        for (int k = 0; k < 256; k++) begin
            @(negedge clk);
            l += int'(pdm_left);
            r += int'(pdm_right);
        end
    endtask

    task automatic put(input logic [31:0] w);
        wr_en = 1'b1; wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load_byte(input logic [7:0] b);
        legacy_wr = 1'b1; legacy_data = b;
        @(negedge clk);
        legacy_wr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R3 actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int l, r, lvl;
        logic [7:0] b;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(q_empty == 1'b1, "R1 empty", int'(q_empty), 1);
        check(q_full == 1'b0, "R1 full", int'(q_full), 0);
        check(q_level == '0, "R1 level", int'(q_level), 0);
        check(underflow == 1'b0, "R1 underflow", int'(underflow), 0);
        measure(l, r);
        check_density("R1 midscale left", l, 128);
        check_density("R1 midscale right", r, 128);

        // R7 legacy byte at reset and after loads
        legacy_en = 1'b1;
        measure(l, r);
        check_density("R7 reset byte left", l, 128);
        check_density("R7 reset byte right", r, 128);
        for (int t = 0; t < 4; t++) begin
            b = (t == 0) ? 8'h00 : (t == 1) ? 8'hFF : 8'($urandom);
            load_byte(b);
            measure(l, r);
            check_density("R7 byte left", l, int'(b));
            check_density("R7 byte right", r, int'(b));
        end

        // R2 / R8 fill while frozen
        words[0] = 32'h8000_7FFF;
        words[1] = 32'h7FFF_8000;
        for (int i = 2; i < DEPTH; i++) words[i] = $urandom;
        for (int i = 0; i < DEPTH; i++) begin
            put(words[i]);
            check(int'(q_level) == i + 1, "R2 level after write", int'(q_level), i + 1);
        end
        check(q_full == 1'b1, "R2 full", int'(q_full), 1);
        put(32'h1234_5678);
        check(int'(q_level) == DEPTH, "R2 write when full", int'(q_level), DEPTH);
        repeat (700) @(negedge clk);
        check(int'(q_level) == DEPTH, "R8 frozen level", int'(q_level), DEPTH);
        check(underflow == 1'b0, "R8 no underflow", int'(underflow), 0);

        // R3 / R4 / R5 drain in order
        legacy_en = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            lvl = int'(q_level);
            while (int'(q_level) == lvl) @(negedge clk);
            check(int'(q_level) == DEPTH - 1 - i, "R3 level after strobe", int'(q_level), DEPTH - 1 - i);
            measure(l, r);
            check_density("R4 R5 left sample", l, exp_ones(words[i][31:16]));
            check_density("R4 R5 right sample", r, exp_ones(words[i][15:0]));
        end
        check(q_empty == 1'b1, "R3 empty after drain", int'(q_empty), 1);
        check(underflow == 1'b0, "R6 no underflow yet", int'(underflow), 0);

        // R6 underflow hold
        repeat (400) @(negedge clk);
        check(underflow == 1'b1, "R6 underflow set", int'(underflow), 1);
        measure(l, r);
        check_density("R6 held left", l, exp_ones(words[DEPTH-1][31:16]));
        check_density("R6 held right", r, exp_ones(words[DEPTH-1][15:0]));

        // R9 write at the strobe edge
        put($urandom); put($urandom); put($urandom);
        lvl = int'(q_level);
        while (int'(q_level) >= lvl) @(negedge clk);
        lvl = int'(q_level);
        repeat (299) @(posedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_data = $urandom;
        @(negedge clk);
        wr_en = 1'b0;
        check(int'(q_level) == lvl, "R9 level with write and strobe", int'(q_level), lvl);
        check(underflow == 1'b1, "R6 underflow sticky", int'(underflow), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule